// File: doc/BRIEF.md
# Trackball Delta Input Port

This block turns two trackball axes and eight switch contacts into two byte-wide input ports for a host processor. Each axis keeps a free-running position counter that moves one step per clock on increment or decrement pulses from an external decoder. The byte's low nibble reports how far the axis has moved since the last reference point. The high nibble passes four active-low switch inputs through unchanged.

A single write strobe from the host's address decoder re-references both axes at once, so later reads show movement from that moment. The same strobe also services a watchdog. If no strobe arrives within a set number of cycles, the watchdog raises a one-cycle reset request and starts counting again.

Top module: `trk_delta_port`

## Requirements
- R1: After synchronous reset, both low nibbles (port1_q[3:0] and port2_q[3:0]) read 0 and wdog_rst_req is low.
- R2: The horizontal axis is reported in port2_q[3:0]. A cycle with horz_up alone adds 1 to it, and a cycle with horz_dn alone subtracts 1. The change is visible after that clock edge.
- R3: The vertical axis is reported in port1_q[3:0] and counts in the opposite sense. A cycle with vert_dn alone adds 1, and a cycle with vert_up alone subtracts 1.
- R4: If an axis has both its up and down inputs high in the same cycle, its position does not change.
- R5: Each nibble equals (position minus reference) taken modulo 2^POS_W and then masked to 4 bits. For example, 17 increments read as 1, and one decrement from zero reads as 15.
- R6: A cycle with rezero_wr high makes both axes' references equal to their positions as they stood before that edge. A step in that same cycle therefore shows as +1 or -1 afterward. With no step, both nibbles read 0.
- R7: port1_q[7:4] equals p1_sw_n[3:0] and port2_q[7:4] equals p2_sw_n[3:0] at all times. Bit 4 is hook left, bit 5 hook right, and bit 6 is the cabinet switch on port 1 and start on port 2. Bit 7 is a coin input.
- R8: If WDOG_CYCLES consecutive clock edges pass with no rezero_wr after reset or after the last strobe, wdog_rst_req is high for exactly one cycle. The count then restarts.
- R9: A rezero_wr strobe restarts the watchdog count, and wdog_rst_req is low in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vert_up | input | 1 | Vertical step pulse, moves position down |
| vert_dn | input | 1 | Vertical step pulse, moves position up |
| horz_up | input | 1 | Horizontal step pulse, moves position up |
| horz_dn | input | 1 | Horizontal step pulse, moves position down |
| p1_sw_n | input | 4 | Active-low switches for port 1 high nibble |
| p2_sw_n | input | 4 | Active-low switches for port 2 high nibble |
| rezero_wr | input | 1 | Host write strobe: re-reference both axes, service watchdog |
| port1_q | output | 8 | Port 1: switches and vertical delta |
| port2_q | output | 8 | Port 2: switches and horizontal delta |
| wdog_rst_req | output | 1 | One-cycle reset request on watchdog expiry |

## Verification
The assertions assume that every input is stable at the rising edge and that the reset is held high from time zero. They also assume that WDOG_CYCLES is at least 2, so an expiry pulse is never followed at once by another one. The stimulus changes every input only on the falling edge and starts with reset asserted. The watchdog timeout the bench uses is small, so it expires within the random run. Strobes are then both withheld and sent often, which covers both expiry and service.

// File: rtl/trk_pkg.sv
package trk_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;

    typedef struct packed {
        logic up;
        logic dn;
    } axis_pulse_t;

    // Turn one pair of pulses into a step. Opposing pulses cancel.
    function automatic step_e step_of(input axis_pulse_t p, input logic reverse);
        step_e s;
        if (p.up == p.dn)
            s = STEP_HOLD;
        else if (p.up ^ reverse)
            s = STEP_INC;
        else
            s = STEP_DEC;
        return s;
    endfunction

endpackage

// File: rtl/trk_axis.sv
module trk_axis
    import trk_pkg::*;
#(
    parameter int POS_W   = 8,
    parameter bit REVERSE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  axis_pulse_t      pulse,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] ONE    = POS_W'(1);
    localparam logic [POS_W-1:0] UP_ADD = REVERSE ? ~POS_W'(0) : ONE;

    step_e step;
    assign step = step_of(pulse, REVERSE);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else begin
            unique case (step)
                STEP_INC: pos <= pos + ONE;
                STEP_DEC: pos <= pos - ONE;
                default:  pos <= pos;
            endcase
        end
    end

    AST_CANCEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pulse.up && pulse.dn) |=> pos == $past(pos)); // R4
    AST_UP_DIRECTION: assert property (@(posedge clk) disable iff (rst)
        (pulse.up && !pulse.dn) |=> pos == POS_W'($past(pos) + UP_ADD)); // R3

endmodule

// File: rtl/trk_ref_delta.sv
module trk_ref_delta #(
    parameter int POS_W = 8,
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [POS_W-1:0] pos,
    output logic [NIB_W-1:0] delta
);
    logic [POS_W-1:0] ref_q;
    logic [POS_W-1:0] diff;

    always_ff @(posedge clk) begin
        if (rst)
            ref_q <= '0;
        else if (capture)
            ref_q <= pos;
    end

    assign diff  = pos - ref_q;
    assign delta = diff[NIB_W-1:0];

endmodule

// File: rtl/trk_wdog.sv
module trk_wdog #(
    parameter int WDOG_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic req
);
    localparam int CW = (WDOG_CYCLES > 2) ? $clog2(WDOG_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WDOG_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          expire;

    assign expire = !kick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            req <= 1'b0;
        end else begin
            req <= expire;
            if (kick || expire)
                cnt <= '0;
            else
                cnt <= cnt + CW'(1);
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        req |=> !req); // R8
    AST_KICK_QUIETS: assert property (@(posedge clk) disable iff (rst)
        kick |=> !req); // R9

endmodule

// File: rtl/trk_delta_port.sv
module trk_delta_port
    import trk_pkg::*;
#(
    parameter int POS_W       = 8,
    parameter int NIB_W       = 4,
    parameter int WDOG_CYCLES = 4096
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vert_up,
    input  logic             vert_dn,
    input  logic             horz_up,
    input  logic             horz_dn,
    input  logic [3:0]       p1_sw_n,
    input  logic [3:0]       p2_sw_n,
    input  logic             rezero_wr,
    output logic [7:0]       port1_q,
    output logic [7:0]       port2_q,
    output logic             wdog_rst_req
);
    localparam int N_AXES = 2;
    // Axis 0 is vertical (reversed sense), axis 1 is horizontal.

    axis_pulse_t      pulses [N_AXES];
    logic [POS_W-1:0] pos    [N_AXES];
    logic [NIB_W-1:0] delta  [N_AXES];

    assign pulses[0] = '{up: vert_up, dn: vert_dn};
    assign pulses[1] = '{up: horz_up, dn: horz_dn};

    for (genvar i = 0; i < N_AXES; i++) begin : g_axis
        trk_axis #(
            .POS_W   (POS_W),
            .REVERSE (i == 0)
        ) u_axis (
            .clk   (clk),
            .rst   (rst),
            .pulse (pulses[i]),
            .pos   (pos[i])
        );

        trk_ref_delta #(
            .POS_W (POS_W),
            .NIB_W (NIB_W)
        ) u_ref (
            .clk     (clk),
            .rst     (rst),
            .capture (rezero_wr),
            .pos     (pos[i]),
            .delta   (delta[i])
        );
    end

    trk_wdog #(
        .WDOG_CYCLES (WDOG_CYCLES)
    ) u_wdog (
        .clk  (clk),
        .rst  (rst),
        .kick (rezero_wr),
        .req  (wdog_rst_req)
    );

    assign port1_q = {p1_sw_n, delta[0]};
    assign port2_q = {p2_sw_n, delta[1]};

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (port1_q[3:0] == '0 && port2_q[3:0] == '0)); // R1
    AST_REZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rezero_wr && !vert_up && !vert_dn && !horz_up && !horz_dn)
        |=> (port1_q[3:0] == '0 && port2_q[3:0] == '0)); // R6
    AST_HORZ_DOWN: assert property (@(posedge clk) disable iff (rst)
        (horz_dn && !horz_up && !rezero_wr)
        |=> port2_q[3:0] == NIB_W'($past(port2_q[3:0]) - 1'b1)); // R2

endmodule

// File: tb/trk_delta_port_test.sv
module trk_delta_port_test;
    localparam int T = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vert_up = 0, vert_dn = 0, horz_up = 0, horz_dn = 0;
    logic [3:0] p1_sw_n = 4'hF, p2_sw_n = 4'hF;
    logic       rezero_wr = 0;
    logic [7:0] port1_q, port2_q;
    logic       wdog_rst_req;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    trk_delta_port #(.WDOG_CYCLES(T)) uut (
        .clk(clk), .rst(rst),
        .vert_up(vert_up), .vert_dn(vert_dn),
        .horz_up(horz_up), .horz_dn(horz_dn),
        .p1_sw_n(p1_sw_n), .p2_sw_n(p2_sw_n),
        .rezero_wr(rezero_wr),
        .port1_q(port1_q), .port2_q(port2_q),
        .wdog_rst_req(wdog_rst_req)
    );

    // Reference model built from the requirements.
    logic [7:0] mh = 0, mv = 0, mhr = 0, mvr = 0;
    int         mw = 0;
    logic       mreq = 0;

    function automatic logic [7:0] stepped(logic [7:0] p, logic inc, logic dec);
        if (inc && !dec) return p + 8'd1;
        if (dec && !inc) return p - 8'd1;
        return p;
    endfunction

    function automatic logic [3:0] nib(logic [7:0] p, logic [7:0] r);
        logic [7:0] d;
        d = p - r;
        return d[3:0];
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            mh <= 0; mv <= 0; mhr <= 0; mvr <= 0; mw <= 0; mreq <= 0;
        end else begin
            mh <= stepped(mh, horz_up, horz_dn);  // R2
            mv <= stepped(mv, vert_dn, vert_up);  // R3 reversed sense
            if (rezero_wr) begin
                mhr <= mh; mvr <= mv;             // R6
            end
            mreq <= !rezero_wr && (mw == T - 1);  // R8
            if (rezero_wr || mw == T - 1) mw <= 0; else mw <= mw + 1;  // R9
        end
    end

    task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", r, act, exp, cycles);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        chk(tag, port1_q, {p1_sw_n, nib(mv, mvr)});
        chk(tag, port2_q, {p2_sw_n, nib(mh, mhr)});
        chk(tag, {7'd0, wdog_rst_req}, {7'd0, mreq});
    endtask

    task automatic drive(logic vu, logic vd, logic hu, logic hd, logic wr);
        vert_up = vu; vert_dn = vd; horz_up = hu; horz_dn = hd; rezero_wr = wr;
        tick();
    endtask

    int pulses_seen;

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) tick();
        rst = 0;
        drive(0, 0, 0, 0, 0);
        chk("R1", {4'd0, port1_q[3:0]}, 8'd0);
        chk("R1", {4'd0, port2_q[3:0]}, 8'd0);

        // R2: horizontal up/down
        tag = "R2";
        repeat (3) drive(0, 0, 1, 0, 1'b0);
        drive(0, 0, 0, 0, 0);
        chk("R2", {4'd0, port2_q[3:0]}, 8'd3);
        repeat (5) drive(0, 0, 0, 1, 0);
        drive(0, 0, 0, 0, 0);
        chk("R2", {4'd0, port2_q[3:0]}, 8'd14);

        // R3: vertical reversed
        tag = "R3";
        repeat (2) drive(0, 1, 0, 0, 0);
        drive(0, 0, 0, 0, 0);
        chk("R3", {4'd0, port1_q[3:0]}, 8'd2);
        repeat (3) drive(1, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0);
        chk("R3", {4'd0, port1_q[3:0]}, 8'd15);

        // R4: opposing pulses cancel
        tag = "R4";
        repeat (4) drive(1, 1, 1, 1, 0);
        drive(0, 0, 0, 0, 0);
        chk("R4", {4'd0, port1_q[3:0]}, 8'd15);
        chk("R4", {4'd0, port2_q[3:0]}, 8'd14);

        // R6: re-reference, and same-cycle step
        tag = "R6";
        drive(0, 0, 0, 0, 1);
        drive(0, 0, 0, 0, 0);
        chk("R6", {port1_q[3:0], port2_q[3:0]}, 8'h00);
        drive(1, 0, 1, 0, 1);
        drive(0, 0, 0, 0, 0);
        chk("R6", {port1_q[3:0], port2_q[3:0]}, 8'hF1);

        // R5: modulo wrap of the difference
        tag = "R5";
        drive(0, 0, 0, 0, 1);
        repeat (17) drive(0, 0, 1, 0, 0);
        drive(0, 0, 0, 0, 0);
        chk("R5", {4'd0, port2_q[3:0]}, 8'd1);
        repeat (2) drive(0, 0, 0, 1, 0);
        drive(0, 0, 0, 0, 0);
        chk("R5", {4'd0, port2_q[3:0]}, 8'd15);

        // R7: switch pass-through
        tag = "R7";
        for (int k = 0; k < 16; k++) begin
            p1_sw_n = 4'(k); p2_sw_n = 4'(15 - k);
            drive(0, 0, 0, 0, 1);
        end
        chk("R7", {port1_q[7:4], port2_q[7:4]}, 8'hF0);

        // R8: expiry pulse with no strobes
        tag = "R8";
        pulses_seen = 0;
        for (int k = 0; k < 2 * T + 2; k++) begin
            drive(0, 0, 0, 0, 0);
            if (wdog_rst_req) pulses_seen++;
        end
        chk("R8", 8'(pulses_seen), 8'd2);

        // R9: frequent strobes keep the watchdog quiet
        tag = "R9";
        pulses_seen = 0;
        for (int k = 0; k < 3 * T; k++) begin
            drive(0, 0, 0, 0, (k % (T / 2)) == 0);
            if (wdog_rst_req) pulses_seen++;
        end
        chk("R9", 8'(pulses_seen), 8'd0);

        // Random mix against the model
        tag = "R5";
        begin
            int unsigned seed_dummy;
            seed_dummy = $urandom(32'd1234);
        end
        for (int k = 0; k < 3000; k++) begin
            p1_sw_n = 4'($urandom); p2_sw_n = 4'($urandom);
            drive(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  ($urandom % 60) == 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule